// File: doc/BRIEF.md
# Memory Channel Status and Clear Controller

This block is a small register file for up to four external memory channels. A 64-bit register port with a byte address, a write strobe and a read strobe gives software two registers. A status word gathers each channel's initialisation-done and calibration-failure inputs together with a per-channel busy flag. A control word carries a clear-request field and a set of general read/write bits.

Writing a one into a channel's clear-request bit starts a background clear of that channel's memory. A per-channel engine then sweeps an address counter over the whole depth. For each address it raises a write-zero request on a request/acknowledge port and moves on only when that request is acknowledged. The busy flag stays set for as long as the sweep runs. The clear-request field cannot be read back. A read of that field returns the bitmap of channels built into this instance, which lets software find out which channels exist.

Top module: `mif_clear_ctrl`

## Requirements
- R1: After reset `rd_data_o` is zero, every `clr_req_o` bit is low and every `clr_addr_o` field is zero.
- R2: A read at byte offset 0x08 (status) returns `init_done_i[i] & CHAN_PRESENT[i]` in bit i, for i = 0..3.
- R3: A status read returns `cal_fail_i[i] & CHAN_PRESENT[i]` in bit 8+i.
- R4: A read at byte offset 0x10 (control) returns `CHAN_PRESENT` in bits [3:0], whatever was written there, and returns in bits [63:4] the value last written to them (zero after reset).
- R5: A control write with bit i set, to a present channel that is idle, raises `clr_req_o[i]` with `clr_addr_o` field i at zero on the next cycle. It also sets status bit 16+i for as long as `clr_req_o[i]` stays high.
- R6: A running clear presents each address from 0 to DEPTH-1 once, in ascending order. It advances only in a cycle where `clr_ack_i[i]` is high and holds the address while the acknowledge is low, so one clear completes exactly DEPTH handshakes.
- R7: `clr_req_o[i]` and status bit 16+i drop in the cycle after the acknowledge for address DEPTH-1.
- R8: A clear request for a channel whose `CHAN_PRESENT` bit is zero is ignored. That channel's request and busy bit stay low.
- R9: A clear request for a channel that is already busy is ignored. Its address does not restart.
- R10: Requests for several idle channels in one write start all of them on the same cycle.
- R11: Reads at any offset other than 0x08 and 0x10 return zero, as do status bits outside [3:0], [11:8] and [19:16]. Writes to the status offset change nothing.
- R12: Read data is registered. It appears on the cycle after `rd_en_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 64 | Registered read data |
| init_done_i | input | 4 | Per-channel initialisation-done |
| cal_fail_i | input | 4 | Per-channel calibration failure |
| clr_req_o | output | 4 | Per-channel write-zero request (also busy) |
| clr_addr_o | output | 4*DAW | Per-channel clear address, channel i at [i*DAW +: DAW] |
| clr_ack_i | input | 4 | Per-channel write-zero acknowledge |

## Verification
The bench targets several corner cases. It writes to control bits [3:0] and then reads them back: a design that stored that field would return the written value in place of the present map. It requests an absent channel: a design that did not gate requests with the present map would raise a request there. It re-requests a channel halfway through a sweep with the acknowledge frozen: a design that restarted the engine would show the address jump back to zero. It stalls the acknowledge and counts handshakes, which catches an engine that skips or repeats an address or drops busy one cycle early or late. A write to the status offset and reads at unmapped offsets catch loose address decoding.

// File: rtl/mif_pkg.sv
package mif_pkg;
  localparam int NCH       = 4;
  localparam int DATA_W    = 64;
  localparam int OFS_STAT  = 'h08;
  localparam int OFS_CTRL  = 'h10;
  localparam int INIT_LSB  = 0;
  localparam int CAL_LSB   = 8;
  localparam int BUSY_LSB  = 16;
  localparam int CLR_W     = 4;

  function automatic logic [DATA_W-1:0] pack_status(
    input logic [NCH-1:0] init_v,
    input logic [NCH-1:0] cal_v,
    input logic [NCH-1:0] busy_v
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[INIT_LSB +: NCH] = init_v;
    w[CAL_LSB  +: NCH] = cal_v;
    w[BUSY_LSB +: NCH] = busy_v;
    return w;
  endfunction
endpackage

// File: rtl/mif_clear_engine.sv
module mif_clear_engine #(
  parameter int DEPTH = 16,
  localparam int DAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           ack_i,
  output logic           busy_o,
  output logic [DAW-1:0] addr_o
);
  localparam logic [DAW-1:0] LAST = DAW'(DEPTH - 1);

  logic           busy_q;
  logic [DAW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      addr_q <= '0;
    end else if (busy_q && ack_i) begin
      if (addr_q == LAST) begin
        busy_q <= 1'b0;
        addr_q <= '0;
      end else begin
        addr_q <= addr_q + DAW'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/mif_reg_file.sv
module mif_reg_file
  import mif_pkg::*;
#(
  parameter int             ADDR_W       = 8,
  parameter logic [NCH-1:0] CHAN_PRESENT = 4'b1011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NCH-1:0]    init_done_i,
  input  logic [NCH-1:0]    cal_fail_i,
  input  logic [NCH-1:0]    busy_i,
  output logic [NCH-1:0]    start_o
);
  localparam int HI_W = DATA_W - CLR_W;

  logic [HI_W-1:0]   ctrl_hi_q;
  logic [DATA_W-1:0] rd_q;
  logic              hit_stat, hit_ctrl;
  logic [DATA_W-1:0] rd_mux;

  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));

  always_comb begin
    rd_mux = '0;
    if (hit_stat)
      rd_mux = pack_status(init_done_i & CHAN_PRESENT, cal_fail_i & CHAN_PRESENT, busy_i);
    else if (hit_ctrl)
      rd_mux = {ctrl_hi_q, CLR_W'(CHAN_PRESENT)};
  end

  // clear field is write-only: it only produces start pulses
  assign start_o = (wr_en_i && hit_ctrl) ? (wr_data_i[NCH-1:0] & CHAN_PRESENT & ~busy_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_hi_q <= '0;
      rd_q      <= '0;
    end else begin
      if (wr_en_i && hit_ctrl) ctrl_hi_q <= wr_data_i[DATA_W-1:CLR_W];
      if (rd_en_i)             rd_q      <= rd_mux;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/mif_clear_ctrl.sv
module mif_clear_ctrl
  import mif_pkg::*;
#(
  parameter int             ADDR_W       = 8,
  parameter int             DEPTH        = 16,
  parameter logic [NCH-1:0] CHAN_PRESENT = 4'b1011,
  localparam int            DAW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [63:0]        wr_data_i,
  input  logic               rd_en_i,
  output logic [63:0]        rd_data_o,
  input  logic [3:0]         init_done_i,
  input  logic [3:0]         cal_fail_i,
  output logic [3:0]         clr_req_o,
  output logic [4*DAW-1:0]   clr_addr_o,
  input  logic [3:0]         clr_ack_i
);
  logic [NCH-1:0] busy, start;

  mif_reg_file #(
    .ADDR_W      (ADDR_W),
    .CHAN_PRESENT(CHAN_PRESENT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .init_done_i(init_done_i),
    .cal_fail_i (cal_fail_i),
    .busy_i     (busy),
    .start_o    (start)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    if (CHAN_PRESENT[g]) begin : g_eng
      mif_clear_engine #(.DEPTH(DEPTH)) u_eng (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(start[g]),
        .ack_i  (clr_ack_i[g]),
        .busy_o (busy[g]),
        .addr_o (clr_addr_o[g*DAW +: DAW])
      );
    end else begin : g_none
      assign busy[g] = 1'b0;
      assign clr_addr_o[g*DAW +: DAW] = '0;
    end
  end

  assign clr_req_o = busy;
endmodule

// File: rtl/mif_clear_ctrl_chk.sv
module mif_clear_ctrl_chk #(
  parameter int         ADDR_W       = 8,
  parameter int         DEPTH        = 16,
  parameter logic [3:0] CHAN_PRESENT = 4'b1011,
  parameter int         DAW          = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [63:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [63:0]       rd_data_o,
  input logic [3:0]        clr_req_o,
  input logic [4*DAW-1:0]  clr_addr_o,
  input logic [3:0]        clr_ack_i
);
  localparam logic [DAW-1:0] LAST = DAW'(DEPTH - 1);

  p_ctrl_rb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'('h10) |=> rd_data_o[3:0] == CHAN_PRESENT);

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i != ADDR_W'('h10) && addr_i != ADDR_W'('h08) |=> rd_data_o == 64'd0);

  p_rd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  for (genvar g = 0; g < 4; g++) begin : g_ch
    p_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == ADDR_W'('h10) && wr_data_i[g] && CHAN_PRESENT[g] && !clr_req_o[g]
      |=> clr_req_o[g] && clr_addr_o[g*DAW +: DAW] == '0);

    p_busy_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && addr_i == ADDR_W'('h08) |=> rd_data_o[16+g] == $past(clr_req_o[g]));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_req_o[g] && !clr_ack_i[g] |=> clr_req_o[g] && $stable(clr_addr_o[g*DAW +: DAW]));

    p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_req_o[g] && clr_ack_i[g] && clr_addr_o[g*DAW +: DAW] != LAST
      |=> clr_req_o[g] && clr_addr_o[g*DAW +: DAW] == $past(clr_addr_o[g*DAW +: DAW]) + DAW'(1));

    p_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_req_o[g] && clr_ack_i[g] && clr_addr_o[g*DAW +: DAW] == LAST |=> !clr_req_o[g]);

    p_absent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !CHAN_PRESENT[g] && wr_en_i |=> !clr_req_o[g]);
  end
endmodule

bind mif_clear_ctrl mif_clear_ctrl_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CHAN_PRESENT(CHAN_PRESENT), .DAW(DAW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .clr_req_o(clr_req_o), .clr_addr_o(clr_addr_o), .clr_ack_i(clr_ack_i)
);

// File: tb/sim_mif_clear_ctrl.sv
`timescale 1ns/1ps
module sim_mif_clear_ctrl;
  localparam int         AW    = 8;
  localparam int         DEPTH = 16;
  localparam int         DAW   = 4;
  localparam logic [3:0] PRES  = 4'b1011;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            wr_en = 1'b0;
  logic [63:0]     wdata = '0;
  logic            rd_en = 1'b0;
  logic [63:0]     rdata;
  logic [3:0]      init_v = '0;
  logic [3:0]      cal_v = '0;
  logic [3:0]      req;
  logic [4*DAW-1:0] caddr;
  logic [3:0]      ack = '0;
  logic [3:0]      ack_en = '0;
  int              pat = 0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mif_clear_ctrl #(.ADDR_W(AW), .DEPTH(DEPTH), .CHAN_PRESENT(PRES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .init_done_i(init_v), .cal_fail_i(cal_v),
    .clr_req_o(req), .clr_addr_o(caddr), .clr_ack_i(ack)
  );

  // acknowledge pattern, changed away from the active edge
  always @(negedge clk) begin
    pat <= pat + 1;
    for (int i = 0; i < 4; i++) ack[i] <= ack_en[i] & (((pat >> i) & 3) != 0);
  end

  // behavioural reference model
  bit          busy_m[4];
  int          adr_m[4];
  logic [59:0] hi_m;
  logic [63:0] rd_m;
  int          hs0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin busy_m[i] = 0; adr_m[i] = 0; end
      hi_m = '0; rd_m = '0; hs0 = 0;
    end else begin
      bit old_b[4];
      logic [63:0] st;
      st = '0;
      for (int i = 0; i < 4; i++) begin
        old_b[i] = busy_m[i];
        st[i]    = init_v[i] & PRES[i];
        st[8+i]  = cal_v[i] & PRES[i];
        st[16+i] = busy_m[i];
      end
      if (rd_en) rd_m = (addr == 8'h08) ? st : (addr == 8'h10) ? {hi_m, PRES} : 64'd0;
      for (int i = 0; i < 4; i++) begin
        if (old_b[i] && ack[i]) begin
          if (i == 0) hs0++;
          if (adr_m[i] == DEPTH - 1) begin busy_m[i] = 0; adr_m[i] = 0; end
          else adr_m[i]++;
        end
      end
      if (wr_en && addr == 8'h10) begin
        hi_m = wdata[63:4];
        for (int i = 0; i < 4; i++)
          if (PRES[i] && wdata[i] && !old_b[i]) begin busy_m[i] = 1; adr_m[i] = 0; end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] rq;
      for (int i = 0; i < 4; i++) begin
        rq[i] = busy_m[i];
        chk("R6 addr", 64'(caddr[i*DAW +: DAW]), 64'(adr_m[i]));
      end
      chk("R5/R7 req", 64'(req), 64'(rq));
      chk("R12 rdata", rdata, rd_m);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && req != 4'b0; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rdata", rdata, 64'd0);
    chk("R1 req", 64'(req), 64'd0);
    chk("R1 addr", 64'(caddr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    init_v = 4'hF; cal_v = 4'h6;
    rd(8'h08);
    chk("R2/R3 status", rdata, 64'h20B);

    wr(8'h10, 64'hFFFF_FFFF_FFFF_FFF0);
    rd(8'h10);
    chk("R4 ctrl readback", rdata, 64'hFFFF_FFFF_FFFF_FFFB);

    wr(8'h10, 64'hA5A5_0000_0000_0004);
    chk("R8 absent req", 64'(req), 64'd0);
    rd(8'h08);
    chk("R8 absent busy", rdata, 64'h20B);
    rd(8'h10);
    chk("R4 write-only field", rdata, 64'hA5A5_0000_0000_000B);

    ack_en = 4'h0;
    wr(8'h10, 64'h1);
    chk("R5 start req", 64'(req), 64'h1);
    chk("R5 start addr", 64'(caddr[DAW-1:0]), 64'd0);
    rd(8'h08);
    chk("R5 busy flag", rdata, 64'h1020B);

    ack_en = 4'h1;
    repeat (6) @(negedge clk);
    ack_en = 4'h0;
    repeat (2) @(negedge clk);
    begin
      logic [DAW-1:0] a0;
      a0 = caddr[DAW-1:0];
      repeat (3) @(negedge clk);
      chk("R6 hold without ack", 64'(caddr[DAW-1:0]), 64'(a0));
      wr(8'h10, 64'h1);
      chk("R9 busy re-request addr", 64'(caddr[DAW-1:0]), 64'(a0));
      chk("R9 busy re-request req", 64'(req[0]), 64'd1);
    end

    ack_en = 4'hF;
    wait_idle();
    @(negedge clk);
    chk("R7 busy drops", 64'(req), 64'd0);
    chk("R6 handshake count", 64'(hs0), 64'(DEPTH));

    ack_en = 4'h0;
    wr(8'h10, 64'hF);
    chk("R10 joint start", 64'(req), 64'hB);
    wr(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h08);
    chk("R11 status write ignored", rdata, 64'h000B_020B);
    rd(8'h00);
    chk("R11 offset 0x00", rdata, 64'd0);
    rd(8'h18);
    chk("R11 offset 0x18", rdata, 64'd0);
    rd(8'h10);
    repeat (3) @(negedge clk);
    chk("R12 read hold", rdata, 64'hB);

    ack_en = 4'hF;
    wait_idle();
    @(negedge clk);
    chk("R7 all idle", 64'(req), 64'd0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule